// File: doc/BRIEF.md
# Two-Wire Full-Bridge Command Decoder

This block turns a pair of direction inputs into switch commands for both legs of a full bridge. Each leg receives a two-bit command, `{highOn, lowOn}`. The encodings are 00 (both switches off, the leg floats), 01 (low switch on) and 10 (high switch on). The four input combinations select forward drive, reverse drive, braking with both low switches closed, or coasting with every switch open.

A current-limit request from an external comparator overrides the drive while the bridge is driving in either direction. One leg is held low and the other leg is chopped. The chopped leg first recirculates fast, with its high switch on, for a programmable number of cycles. It then settles into slow recirculation, with its low switch on, until the request is withdrawn.

When both inputs stay low long enough, the block enters a low-power sleep state. The first input that goes high wakes it. All switches are then held open for a programmable settling time, so the supply can recover before any drive takes effect. All switches are also held open during the power-up hold after reset, and while the undervoltage flag or the over-temperature flag is raised. The sense comparators, the supply pump and the gate drivers are outside this block and report to it as digital flags.

Top module: `bridge_cmd_decoder`

## Requirements
- R1: With dirA=1, dirB=0 and no current-limit request, one clock after sampling, legA=10 and legB=01 (forward).
- R2: With dirA=0, dirB=1 and no current-limit request, one clock after sampling, legA=01 and legB=10 (reverse).
- R3: With dirA=dirB=1, one clock after sampling, legA=legB=01 (brake).
- R4: With dirA=dirB=0, one clock after sampling, legA=legB=00 (coast).
- R5: In forward drive with chopReq high, legA=01. legB=10 for the first FAST_CYCLES sampled cycles of an unbroken request, and legB=01 after that.
- R6: In reverse drive with chopReq high, legB=01. legA=10 for the first FAST_CYCLES sampled cycles of an unbroken request, and legA=01 after that.
- R7: chopReq has no effect while braking or coasting.
- R8: sleepMode rises after dirA=dirB=0 has been sampled on SLEEP_CYCLES consecutive edges. Any input sampled high restarts this count. While sleepMode is high, both legs are 00.
- R9: In sleep, the first edge that samples either input high clears sleepMode. Both legs then stay 00 until WAKE_CYCLES further edges have passed, and the edge after those drives the decoded command.
- R10: On the edge after uvloFlag or thermFlag is sampled high, both legs read 00.
- R11: After reset, both legs are 00 and sleepMode is 0. The decoded command first appears on the (PWRUP_CYCLES+1)-th edge after reset is released.
- R12: Neither leg ever reads 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirA | input | 1 | First direction input |
| dirB | input | 1 | Second direction input |
| chopReq | input | 1 | Current-limit request from the sense comparator |
| uvloFlag | input | 1 | Supply undervoltage flag |
| thermFlag | input | 1 | Over-temperature flag |
| legA | output | 2 | Leg A command {highOn, lowOn} |
| legB | output | 2 | Leg B command {highOn, lowOn} |
| sleepMode | output | 1 | High while in low-power sleep |

## Verification
The sharpest collision occurs when a wake-up edge and a current-limit request land in the same cycle. The chop phase counter then runs while the outputs are still held open. When the hold expires, the chopped leg may already be in slow recirculation. A second collision occurs when a fault flag is raised on the very edge that completes the idle count, so the block enters sleep while a forced-off condition is also active. The random stimulus makes long all-low stretches, short direction bursts and scattered flag and chop pulses, which produce both overlaps many times. A cycle-level model in the bench, written from the requirements, gives the expected leg commands and sleep state on every cycle.

// File: rtl/bridge_cmd_pkg.sv
package bridge_cmd_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_LOW  = 2'b01,
    LEG_HIGH = 2'b10
  } legDrive_e;

  typedef struct packed {
    logic block;      // force every switch open
    logic fastPhase;  // chopped leg recirculates through its high switch
  } ctrlStrb_t;

endpackage

// File: rtl/bridge_cmd_ctrl.sv
module bridge_cmd_ctrl
  import bridge_cmd_pkg::*;
#(
  parameter int SLEEP_CYCLES = 200000,
  parameter int WAKE_CYCLES  = 40000,
  parameter int PWRUP_CYCLES = 6000,
  parameter int FAST_CYCLES  = 2500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      dirA,
  input  logic      dirB,
  input  logic      chopReq,
  input  logic      uvloFlag,
  input  logic      thermFlag,
  output ctrlStrb_t strb,
  output logic      sleepMode
);

  localparam int IDLE_W   = $clog2(SLEEP_CYCLES + 1);
  localparam int HOLD_MAX = (WAKE_CYCLES > PWRUP_CYCLES) ? WAKE_CYCLES : PWRUP_CYCLES;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
  localparam int CHOP_W   = $clog2(FAST_CYCLES + 1);

  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(SLEEP_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_TOP  = IDLE_W'(SLEEP_CYCLES);
  localparam logic [HOLD_W-1:0] WAKE_LOAD = HOLD_W'(WAKE_CYCLES);
  localparam logic [HOLD_W-1:0] PWR_LOAD  = HOLD_W'(PWRUP_CYCLES);
  localparam logic [CHOP_W-1:0] FAST_TOP  = CHOP_W'(FAST_CYCLES);

  logic [IDLE_W-1:0] idleCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic [CHOP_W-1:0] chopCnt;
  logic              sleepReg;
  logic              anyHigh;

  assign anyHigh = dirA | dirB;

  // Idle timer: counts consecutive all-low samples, saturating.
  always_ff @(posedge clk) begin
    if (!rstN)             idleCnt <= '0;
    else if (anyHigh)      idleCnt <= '0;
    else if (idleCnt != IDLE_TOP) idleCnt <= idleCnt + 1'b1;
  end

  // Sleep state and output hold-off (power-up and wake-up share one counter).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepReg <= 1'b0;
      holdCnt  <= PWR_LOAD;
    end else if (sleepReg && anyHigh) begin
      sleepReg <= 1'b0;
      holdCnt  <= WAKE_LOAD;
    end else begin
      if (!sleepReg && !anyHigh && idleCnt == IDLE_LAST) sleepReg <= 1'b1;
      if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
    end
  end

  // Chop phase counter: length of the current unbroken request.
  always_ff @(posedge clk) begin
    if (!rstN || !chopReq)       chopCnt <= '0;
    else if (chopCnt != FAST_TOP) chopCnt <= chopCnt + 1'b1;
  end

  always_comb begin
    strb.block     = sleepReg || (holdCnt != '0) || uvloFlag || thermFlag;
    strb.fastPhase = (chopCnt < FAST_TOP);
  end

  assign sleepMode = sleepReg;

endmodule

// File: rtl/bridge_cmd_path.sv
module bridge_cmd_path
  import bridge_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dirA,
  input  logic      dirB,
  input  logic      chopReq,
  input  ctrlStrb_t strb,
  output legDrive_e legA,
  output legDrive_e legB
);

  legDrive_e nextA, nextB;
  legDrive_e chopLeg;

  assign chopLeg = strb.fastPhase ? LEG_HIGH : LEG_LOW;

  always_comb begin
    nextA = LEG_OFF;
    nextB = LEG_OFF;
    if (!strb.block) begin
      unique case ({dirA, dirB})
        2'b10: begin
          nextA = chopReq ? LEG_LOW : LEG_HIGH;
          nextB = chopReq ? chopLeg : LEG_LOW;
        end
        2'b01: begin
          nextA = chopReq ? chopLeg : LEG_LOW;
          nextB = chopReq ? LEG_LOW : LEG_HIGH;
        end
        2'b11: begin
          nextA = LEG_LOW;
          nextB = LEG_LOW;
        end
        default: begin
          nextA = LEG_OFF;
          nextB = LEG_OFF;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      legA <= LEG_OFF;
      legB <= LEG_OFF;
    end else begin
      legA <= nextA;
      legB <= nextB;
    end
  end

endmodule

// File: rtl/bridge_cmd_decoder.sv
module bridge_cmd_decoder
  import bridge_cmd_pkg::*;
#(
  parameter int SLEEP_CYCLES = 200000,
  parameter int WAKE_CYCLES  = 40000,
  parameter int PWRUP_CYCLES = 6000,
  parameter int FAST_CYCLES  = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirA,
  input  logic       dirB,
  input  logic       chopReq,
  input  logic       uvloFlag,
  input  logic       thermFlag,
  output logic [1:0] legA,
  output logic [1:0] legB,
  output logic       sleepMode
);

  ctrlStrb_t strb;
  legDrive_e legAInt, legBInt;

  bridge_cmd_ctrl #(
    .SLEEP_CYCLES(SLEEP_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES),
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .FAST_CYCLES (FAST_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dirA     (dirA),
    .dirB     (dirB),
    .chopReq  (chopReq),
    .uvloFlag (uvloFlag),
    .thermFlag(thermFlag),
    .strb     (strb),
    .sleepMode(sleepMode)
  );

  bridge_cmd_path i_path (
    .clk    (clk),
    .rstN   (rstN),
    .dirA   (dirA),
    .dirB   (dirB),
    .chopReq(chopReq),
    .strb   (strb),
    .legA   (legAInt),
    .legB   (legBInt)
  );

  assign legA = legAInt;
  assign legB = legBInt;

endmodule

// File: rtl/bridge_cmd_chk.sv
module bridge_cmd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dirA,
  input logic       dirB,
  input logic       chopReq,
  input logic       uvloFlag,
  input logic       thermFlag,
  input logic [1:0] legA,
  input logic [1:0] legB,
  input logic       sleepMode
);

  // R12
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (legA != 2'b11) && (legB != 2'b11));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepMode |-> (legA == 2'b00) && (legB == 2'b00));

  // R8
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepMode) |-> $past(!dirA && !dirB));

  // R10
  fault_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uvloFlag || thermFlag) |=> (legA == 2'b00) && (legB == 2'b00));

  // R3
  brake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirA && dirB) |=> (legA == legB) && (legA != 2'b10));

  // R4
  coast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dirA && !dirB) |=> (legA == 2'b00) && (legB == 2'b00));

endmodule

bind bridge_cmd_decoder bridge_cmd_chk i_chk (.*);

// File: tb/test_bridge_cmd_decoder.sv
`timescale 1ns/1ps
module test_bridge_cmd_decoder;

  localparam int SLEEP = 40;
  localparam int WAKE  = 12;
  localparam int PWRUP = 8;
  localparam int FAST  = 5;
  localparam int ITER  = 30000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirA = 1'b0, dirB = 1'b0, chopReq = 1'b0, uvloFlag = 1'b0, thermFlag = 1'b0;
  logic [1:0] legA, legB;
  logic sleepMode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // model state
  bit    mSleep;
  int    mIdle, mHold, mChop;
  bit    mWakeHold;
  logic [1:0] expA, expB;
  bit    expSleep;
  string legTag;

  always #2.5 clk = ~clk;

  bridge_cmd_decoder #(
    .SLEEP_CYCLES(SLEEP), .WAKE_CYCLES(WAKE),
    .PWRUP_CYCLES(PWRUP), .FAST_CYCLES(FAST)
  ) i_bridge_cmd_decoder (
    .clk(clk), .rstN(rstN), .dirA(dirA), .dirB(dirB), .chopReq(chopReq),
    .uvloFlag(uvloFlag), .thermFlag(thermFlag),
    .legA(legA), .legB(legB), .sleepMode(sleepMode)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] decode(input bit a, input bit b, input bit chop, input bit fast);
    logic [1:0] cl;
    cl = fast ? 2'b10 : 2'b01;
    case ({a, b})
      2'b10:   return chop ? {2'b01, cl} : 4'b1001;   // R1 / R5
      2'b01:   return chop ? {cl, 2'b01} : 4'b0110;   // R2 / R6
      2'b11:   return 4'b0101;                        // R3
      default: return 4'b0000;                        // R4
    endcase
  endfunction

  // advance the model by one clock edge using the inputs now driven
  task automatic modelStep();
    bit blk, anyHigh;
    blk = mSleep || (mHold != 0) || uvloFlag || thermFlag;
    anyHigh = dirA || dirB;
    {expA, expB} = blk ? 4'b0000 : decode(dirA, dirB, chopReq, mChop < FAST);
    if (uvloFlag || thermFlag) legTag = "R10";
    else if (mSleep || (mHold != 0 && mWakeHold)) legTag = "R9";
    else if (mHold != 0) legTag = "R11";
    else if (chopReq && dirA && !dirB) legTag = "R5";
    else if (chopReq && !dirA && dirB) legTag = "R6";
    else if (chopReq) legTag = "R7";
    else if (dirA && !dirB) legTag = "R1";
    else if (!dirA && dirB) legTag = "R2";
    else if (dirA) legTag = "R3";
    else legTag = "R4";
    // state update
    if (mSleep && anyHigh) begin
      mSleep = 1'b0; mHold = WAKE; mWakeHold = 1'b1;
    end else begin
      if (!mSleep && !anyHigh && mIdle == SLEEP - 1) mSleep = 1'b1;
      if (mHold != 0) mHold--;
    end
    if (anyHigh) mIdle = 0; else if (mIdle != SLEEP) mIdle++;
    if (!chopReq) mChop = 0; else if (mChop != FAST) mChop++;
    expSleep = mSleep;
  endtask

  task automatic cycle();
    modelStep();
    @(negedge clk);
    check(legTag, {legA, legB}, {expA, expB});
    check("R8", {3'b000, sleepMode}, {3'b000, expSleep});
    check("R12", {2'b00, (legA == 2'b11), (legB == 2'b11)}, 4'b0000);
  endtask

  task automatic drive(input bit a, input bit b, input bit c, input int n);
    for (int i = 0; i < n; i++) begin
      dirA = a; dirB = b; chopReq = c;
      cycle();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {legA, legB}, 4'b0000);
    check("R11", {3'b000, sleepMode}, 4'b0000);
    mSleep = 0; mIdle = 0; mHold = PWRUP; mChop = 0; mWakeHold = 0;
    rstN = 1'b1;
    // R11 power-up hold then forward
    drive(1, 0, 0, PWRUP + 3);
    // R5 forward chop through fast into slow phase
    drive(1, 0, 1, FAST + 4);
    // R6 reverse chop
    drive(0, 1, 1, FAST + 4);
    // R7 chop during brake and coast
    drive(1, 1, 1, 4);
    // R8 idle count restarted one short of the limit
    drive(0, 0, 0, SLEEP - 1);
    drive(0, 1, 0, 1);
    drive(0, 0, 0, SLEEP + 3);
    // R9 wake together with a chop request
    drive(1, 0, 1, WAKE + 6);
    // R10 fault during drive
    uvloFlag = 1'b1; drive(0, 1, 0, 3); uvloFlag = 1'b0;
    thermFlag = 1'b1; drive(1, 1, 0, 2); thermFlag = 1'b0;
    // constrained random
    for (int it = 0; it < ITER; ) begin
      int kind, len;
      bit a, b;
      kind = $urandom % 8;
      len = (kind == 0) ? SLEEP - 3 + int'($urandom % 10) : 1 + int'($urandom % 20);
      {a, b} = (kind == 0) ? 2'b00 : 2'($urandom);
      for (int j = 0; j < len; j++) begin
        dirA = a; dirB = b;
        if ($urandom % 4 == 0) chopReq = ~chopReq;
        uvloFlag  = ($urandom % 40 == 0);
        thermFlag = ($urandom % 50 == 0);
        cycle();
        it++;
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule